// File: doc/BRIEF.md
# Register-Mapped CRC-32 Engine

This block keeps a running 32-bit CRC that software advances by writing whole 32-bit words to a data register. Each word is folded in most-significant bit first against a polynomial that software can change. The state starts from an initial value that software can also change. Before a word is folded in, its bits can be mirrored inside each byte, inside each half-word or across the whole word. The value read back from the data register can be mirrored across all 32 bits as well. The hardware applies no final inversion, so software inverts the read value itself when it needs a standard reflected CRC-32.

A small controller with two named states handles reloads. In `CTL_IDLE`, a write to the control register with the reload bit set copies the initial value into the CRC state and moves the controller to `CTL_RELOAD` (transition *reload-request*). In `CTL_RELOAD` the reload bit reads back as 1. On the next clock the controller returns to `CTL_IDLE` (transition *self-clear*), unless a new reload request arrives in that same cycle, in which case it stays in `CTL_RELOAD` (transition *reload-again*).

The bus is a single-cycle strobe interface. A write takes effect at the clock edge on which `wr_en` is high. `rdata` is combinational from the register state and is valid in the same cycle as `rd_en`.

Top module: `crc32_unit`

## Requirements
- R1: After reset, the polynomial reads 0x04C11DB7, the initial value reads 0xFFFFFFFF, the data register reads 0xFFFFFFFF, and both the control and scratch registers read 0.
- R2: Writing the control register (0x08) with bit 0 set loads the initial value into the CRC state. Bit 0 then reads 1 in the next cycle and 0 in later cycles. Writing the initial value register alone does not reload the state.
- R3: A write to data (0x00) folds the full 32-bit word into the state, MSB first, in one clock, and a read in the following cycle returns the new state. From 0xFFFFFFFF with no reversal, writing word 0 reads back 0xC704DD7B.
- R4: Control bits [2:1] select input reversal: 00 none, 01 within each byte, 10 within each half-word, 11 across all 32 bits. With output reversal on, writing word 0x00010203 after a reload reads back 0x5493B6D6, 0x744679EC, 0xA3247569 and 0xD6916A22 for these four settings.
- R5: Control bit 3 enables output reversal, which mirrors all 32 bits of the data register's read value. Writing word 0 after a reload then reads back 0xDEBB20E3.
- R6: The scratch register at 0x04 stores any 32-bit value and has no effect on the CRC state.
- R7: The polynomial register at 0x14 and the initial value register at 0x10 are writable. A new polynomial is used from the next data write on. Writing the polynomial, or writing the control register with bit 0 clear, leaves the CRC state unchanged.
- R8: Reads from unmapped offsets return 0, and `rdata` is 0 whenever `rd_en` is low.
- R9: Successive data writes accumulate: the state after N words equals N chained single-word updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | 5 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational, 0 when no read |

## Verification
An all-zero word is used first: it looks the same under every input reversal, so it checks the polynomial division and the output mirror on their own. The word 0x00010203 has an asymmetric bit pattern, so it is applied under each of the four input-reversal settings, and each setting must produce its own distinct result. A long random mix of reads and writes to all offsets, including reloads, polynomial changes and writes to unmapped offsets, is then compared every cycle against a behavioural model. This tests accumulation over many words and shows that settings changes do not disturb the state.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
    localparam int OFS_DATA  = 'h00;
    localparam int OFS_SCR   = 'h04;
    localparam int OFS_CTRL  = 'h08;
    localparam int OFS_INIT  = 'h10;
    localparam int OFS_POLY  = 'h14;

    localparam int CTRL_RELOAD_BIT = 0;
    localparam int CTRL_INREV_LSB  = 1;
    localparam int CTRL_OUTREV_BIT = 3;

    typedef enum logic [1:0] {
        REFL_NONE = 2'b00,
        REFL_BYTE = 2'b01,
        REFL_HALF = 2'b10,
        REFL_WORD = 2'b11
    } refl_mode_e;

    typedef enum logic {
        CTL_IDLE   = 1'b0,
        CTL_RELOAD = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/crc_bit_reflect.sv
module crc_bit_reflect #(
    parameter int W = 32
) (
    input  logic [W-1:0]        din,
    input  crc32_pkg::refl_mode_e mode,
    output logic [W-1:0]        dout
);
    localparam int NBYTE = W / 8;
    localparam int NHALF = W / 16;

    logic [W-1:0] by_byte;
    logic [W-1:0] by_half;
    logic [W-1:0] by_word;

    for (genvar g = 0; g < NBYTE; g++) begin : g_byte
        for (genvar b = 0; b < 8; b++) begin : g_bit
            assign by_byte[g*8 + b] = din[g*8 + 7 - b];
        end
    end

    for (genvar h = 0; h < NHALF; h++) begin : g_half
        for (genvar b = 0; b < 16; b++) begin : g_bit
            assign by_half[h*16 + b] = din[h*16 + 15 - b];
        end
    end

    for (genvar b = 0; b < W; b++) begin : g_word
        assign by_word[b] = din[W - 1 - b];
    end

    always_comb begin
        unique case (mode)
            crc32_pkg::REFL_NONE: dout = din;
            crc32_pkg::REFL_BYTE: dout = by_byte;
            crc32_pkg::REFL_HALF: dout = by_half;
            crc32_pkg::REFL_WORD: dout = by_word;
            default:              dout = din;
        endcase
    end
endmodule

// File: rtl/crc_word_step.sv
module crc_word_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] crc_in,
    input  logic [W-1:0] word,
    input  logic [W-1:0] poly,
    output logic [W-1:0] crc_out
);
    always_comb begin
        logic [W-1:0] acc;
        logic         fb;
        acc = crc_in;
        for (int i = W - 1; i >= 0; i--) begin
            fb  = acc[W-1] ^ word[i];
            acc = {acc[W-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/crc32_unit.sv
module crc32_unit #(
    parameter int          CRC_W    = 32,
    parameter int          ADDR_W   = 5,
    parameter logic [31:0] POLY_RST = 32'h04C1_1DB7,
    parameter logic [31:0] INIT_RST = 32'hFFFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CRC_W-1:0]  wdata,
    output logic [CRC_W-1:0]  rdata
);
    import crc32_pkg::*;

    localparam int CTRL_PAD = CRC_W - 4;

    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] init_q;
    logic [CRC_W-1:0] poly_q;
    logic [CRC_W-1:0] scr_q;
    refl_mode_e       inrev_q;
    logic             outrev_q;
    ctl_state_e       st_q, st_d;

    logic sel_data, sel_scr, sel_ctrl, sel_init, sel_poly;
    logic wr_data, wr_ctrl, reload_req;
    logic reload_pend;

    logic [CRC_W-1:0] word_refl;
    logic [CRC_W-1:0] crc_next;
    logic [CRC_W-1:0] crc_view;

    assign sel_data = (addr == ADDR_W'(OFS_DATA));
    assign sel_scr  = (addr == ADDR_W'(OFS_SCR));
    assign sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
    assign sel_init = (addr == ADDR_W'(OFS_INIT));
    assign sel_poly = (addr == ADDR_W'(OFS_POLY));

    assign wr_data    = wr_en && sel_data;
    assign wr_ctrl    = wr_en && sel_ctrl;
    assign reload_req = wr_ctrl && wdata[CTRL_RELOAD_BIT];

    crc_bit_reflect #(.W(CRC_W)) in_refl_i (
        .din  (wdata),
        .mode (inrev_q),
        .dout (word_refl)
    );

    crc_word_step #(.W(CRC_W)) step_i (
        .crc_in  (crc_q),
        .word    (word_refl),
        .poly    (poly_q),
        .crc_out (crc_next)
    );

    crc_bit_reflect #(.W(CRC_W)) out_refl_i (
        .din  (crc_q),
        .mode (outrev_q ? REFL_WORD : REFL_NONE),
        .dout (crc_view)
    );

    // Reload controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTL_IDLE;
        else        st_q <= st_d;
    end

    // Reload controller: transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CTL_IDLE:   st_d = reload_req ? CTL_RELOAD : CTL_IDLE;
            CTL_RELOAD: st_d = reload_req ? CTL_RELOAD : CTL_IDLE;
            default:    st_d = CTL_IDLE;
        endcase
    end

    // Reload controller: outputs
    always_comb begin
        reload_pend = 1'b0;
        unique case (st_q)
            CTL_IDLE:   reload_pend = 1'b0;
            CTL_RELOAD: reload_pend = 1'b1;
            default:    reload_pend = 1'b0;
        endcase
    end

    // Configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_q   <= INIT_RST;
            poly_q   <= POLY_RST;
            scr_q    <= '0;
            inrev_q  <= REFL_NONE;
            outrev_q <= 1'b0;
        end else if (wr_en) begin
            if (sel_init) init_q <= wdata;
            if (sel_poly) poly_q <= wdata;
            if (sel_scr)  scr_q  <= wdata;
            if (sel_ctrl) begin
                inrev_q  <= refl_mode_e'(wdata[CTRL_INREV_LSB +: 2]);
                outrev_q <= wdata[CTRL_OUTREV_BIT];
            end
        end
    end

    // CRC state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          crc_q <= INIT_RST;
        else if (reload_req) crc_q <= init_q;
        else if (wr_data)    crc_q <= crc_next;
    end

    // Read mux
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel_data)      rdata = crc_view;
            else if (sel_scr)  rdata = scr_q;
            else if (sel_ctrl) rdata = {{CTRL_PAD{1'b0}}, outrev_q, inrev_q, reload_pend};
            else if (sel_init) rdata = init_q;
            else if (sel_poly) rdata = poly_q;
        end
    end
endmodule

// File: rtl/crc32_unit_chk.sv
module crc32_unit_chk #(
    parameter int CRC_W  = 32,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CRC_W-1:0]  wdata,
    input logic [CRC_W-1:0]  rdata,
    input logic [CRC_W-1:0]  crc_q,
    input logic [CRC_W-1:0]  init_q,
    input logic              reload_pend
);
    logic mapped;
    assign mapped = (addr == ADDR_W'('h00)) || (addr == ADDR_W'('h04)) ||
                    (addr == ADDR_W'('h08)) || (addr == ADDR_W'('h10)) ||
                    (addr == ADDR_W'('h14));

    logic req_now;
    assign req_now = wr_en && (addr == ADDR_W'('h08)) && wdata[0];

    a_r2_reload_loads_init: assert property (@(posedge clk) disable iff (!rst_n)
        req_now |=> (crc_q == $past(init_q)));

    a_r2_flag_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
        req_now |=> reload_pend);

    a_r2_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reload_pend && !req_now) |=> !reload_pend);

    a_r6_scratch_no_effect: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'('h04)) |=> $stable(crc_q));

    a_r7_poly_write_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'('h14)) |=> $stable(crc_q));

    a_r7_ctrl_no_reload_keeps_state: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'('h08) && !wdata[0]) |=> $stable(crc_q));

    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |-> (rdata == '0));

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

bind crc32_unit crc32_unit_chk #(.CRC_W(CRC_W), .ADDR_W(ADDR_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .crc_q       (crc_q),
    .init_q      (init_q),
    .reload_pend (reload_pend)
);

// File: tb/crc32_unit_tb_top.sv
`timescale 1ns/1ps
module crc32_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [31:0] last_rd;

    always #2 clk = ~clk;

    crc32_unit dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Behavioural reference model
    logic [31:0] m_crc, m_init, m_poly, m_scr;
    int          m_inrev;
    bit          m_outrev, m_pend;

    function automatic logic [31:0] mirror(logic [31:0] v, int mode);
        logic [31:0] r;
        int grp;
        grp = (mode == 1) ? 8 : (mode == 2) ? 16 : (mode == 3) ? 32 : 0;
        if (grp == 0) return v;
        for (int i = 0; i < 32; i++)
            r[i] = v[(i / grp) * grp + (grp - 1) - (i % grp)];
        return r;
    endfunction

    function automatic logic [31:0] fold(logic [31:0] s, logic [31:0] w, logic [31:0] p);
        for (int k = 31; k >= 0; k--) begin
            if (s[31] != w[k]) s = (s << 1) ^ p;
            else               s = s << 1;
        end
        return s;
    endfunction

    function automatic logic [31:0] m_read(logic [4:0] a);
        case (a)
            5'h00:   return m_outrev ? mirror(m_crc, 3) : m_crc;
            5'h04:   return m_scr;
            5'h08:   return {28'd0, m_outrev, 2'(m_inrev), m_pend};
            5'h10:   return m_init;
            5'h14:   return m_poly;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_crc <= 32'hFFFFFFFF; m_init <= 32'hFFFFFFFF; m_poly <= 32'h04C11DB7;
            m_scr <= 0; m_inrev <= 0; m_outrev <= 0; m_pend <= 0;
        end else begin
            m_pend <= wr_en && addr == 5'h08 && wdata[0];
            if (wr_en) begin
                case (addr)
                    5'h00: m_crc <= fold(m_crc, mirror(wdata, m_inrev), m_poly);
                    5'h04: m_scr <= wdata;
                    5'h08: begin
                        m_inrev <= int'(wdata[2:1]);
                        m_outrev <= wdata[3];
                        if (wdata[0]) m_crc <= m_init;
                    end
                    5'h10: m_init <= wdata;
                    5'h14: m_poly <= wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    // One bus cycle; every read is compared with the model in that cycle
    task automatic cyc(bit we, bit re, logic [4:0] a, logic [31:0] d, string req);
        @(negedge clk);
        wr_en = we; rd_en = re; addr = a; wdata = d;
        #1;
        last_rd = rdata;
        if (re) check(req, rdata, m_read(a));
        else    check("R8 idle rdata", rdata, 32'd0);
    endtask

    task automatic rd_lit(logic [4:0] a, logic [31:0] exp, string req);
        cyc(0, 1, a, 0, req);
        check(req, last_rd, exp);
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_lit(5'h14, 32'h04C11DB7, "R1 poly");
        rd_lit(5'h10, 32'hFFFFFFFF, "R1 init");
        rd_lit(5'h00, 32'hFFFFFFFF, "R1 data");
        rd_lit(5'h08, 32'h0, "R1 ctrl");
        rd_lit(5'h04, 32'h0, "R1 scratch");

        // R3 zero word, no reversal
        cyc(1, 0, 5'h08, 32'h1, "R2");
        rd_lit(5'h08, 32'h1, "R2 flag set");
        rd_lit(5'h08, 32'h0, "R2 flag cleared");
        cyc(1, 0, 5'h00, 32'h0, "R3");
        rd_lit(5'h00, 32'hC704DD7B, "R3 zero word");

        // R5 output reversal
        cyc(1, 0, 5'h08, 32'h9, "R5");
        cyc(1, 0, 5'h00, 32'h0, "R5");
        rd_lit(5'h00, 32'hDEBB20E3, "R5 mirrored");

        // R4 input reversal modes
        cyc(1, 0, 5'h08, 32'h9, "R4");
        cyc(1, 0, 5'h00, 32'h00010203, "R4");
        rd_lit(5'h00, 32'h5493B6D6, "R4 none");
        cyc(1, 0, 5'h08, 32'hB, "R4");
        cyc(1, 0, 5'h00, 32'h00010203, "R4");
        rd_lit(5'h00, 32'h744679EC, "R4 byte");
        cyc(1, 0, 5'h08, 32'hD, "R4");
        cyc(1, 0, 5'h00, 32'h00010203, "R4");
        rd_lit(5'h00, 32'hA3247569, "R4 half");
        cyc(1, 0, 5'h08, 32'hF, "R4");
        cyc(1, 0, 5'h00, 32'h00010203, "R4");
        rd_lit(5'h00, 32'hD6916A22, "R4 word");

        // R6 scratch has no effect
        cyc(1, 0, 5'h04, 32'hA5A5_5A5A, "R6");
        rd_lit(5'h00, 32'hD6916A22, "R6 state kept");
        rd_lit(5'h04, 32'hA5A5_5A5A, "R6 scratch");

        // R7 init write alone does not reload, poly write keeps state
        cyc(1, 0, 5'h10, 32'h1234_5678, "R7");
        rd_lit(5'h00, 32'hD6916A22, "R7 init no reload");
        cyc(1, 0, 5'h14, 32'h1EDC_6F41, "R7");
        rd_lit(5'h00, 32'hD6916A22, "R7 poly keeps state");
        cyc(1, 0, 5'h08, 32'h1, "R2");
        rd_lit(5'h00, 32'h1234_5678, "R2 reload new init");
        cyc(1, 0, 5'h00, 32'hDEAD_BEEF, "R7 new poly");
        rd_lit(5'h00, fold(32'h1234_5678, 32'hDEAD_BEEF, 32'h1EDC_6F41), "R7 new poly");

        // R8 unmapped
        rd_lit(5'h0C, 32'h0, "R8 unmapped 0C");
        rd_lit(5'h1C, 32'h0, "R8 unmapped 1C");

        // R9 random streaming against the model
        for (int n = 0; n < 3000; n++) begin
            logic [4:0] a;
            int pick;
            pick = $urandom_range(0, 19);
            a = (pick < 10) ? 5'h00 : 5'(4 * $urandom_range(0, 7));
            cyc(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)), a, $urandom, "R9 stream");
        end

        cyc(0, 0, 5'h00, 0, "R8");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule